// File: doc/BRIEF.md
# Auxiliary Video Information Packet Builder

This block builds the 17-byte auxiliary video information packet that a display link sends next to the pixel data. A one-cycle start pulse latches the pixel clock (in kHz) and the active width and height. The block encodes colorimetry and picture aspect into one descriptor byte. It then makes one pass over all 17 bytes to form an 8-bit two's-complement checksum. After that pass it streams the finished packet, one byte per accepted transfer, with the byte index and an end-of-packet flag.

The output is a valid/ready stream. `pkt_valid_o` stays high from the first byte until the final byte is accepted. A transfer happens on any rising clock edge where valid and ready are both high. While ready is low, the data, index and last flag stay frozen, and the block waits indefinitely. If ready is held high, the packet goes out as 17 back-to-back transfers. `busy_o` is high from the accepted start until the final transfer. Start pulses that arrive while busy are dropped. Input changes after the start are not seen.

Top module: `avi_pkt_builder`

## Requirements
- R1: After reset `pkt_valid_o` and `busy_o` are low.
- R2: A start pulse is taken only while the block is idle. The captured pixel clock and resolution are the values present on the accepting edge. A start pulse or input change while `busy_o` is high has no effect on the packet in progress.
- R3: `pkt_valid_o` first rises exactly 17 clock edges after the edge that accepted the start. This gap is the checksum pass.
- R4: Bytes leave in index order 0 to 16, starting at index 0. `pkt_idx_o` carries the index. `pkt_last_o` is high only with index 16. Index 0 is 0x82, index 1 is 0x02, index 2 is 0x0D, index 4 is 0x12 and index 6 is 0x88. Indices 7 to 16 are 0x00.
- R5: At index 5, bits [7:6] encode colorimetry. A pixel clock of at most 27000 kHz gives 0x40. Any higher clock gives 0x80.
- R6: At index 5, bits [5:3] encode picture aspect. If floor(width*100/height) is below 156, the field is ORed with 0x18. Otherwise it is ORed with 0x28.
- R7: A height of zero selects the 0x28 aspect code.
- R8: Byte index 3 holds the checksum. It is 0x100 minus the 8-bit sum of the other bytes, so the 17 emitted bytes sum to 0 modulo 256.
- R9: While `pkt_valid_o` is high and `pkt_ready_i` is low, the data, index and last outputs hold their values.
- R10: On the edge after the final transfer, `pkt_valid_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Build request pulse |
| pclk_khz_i | input | CLK_W | Pixel clock in kHz |
| h_act_i | input | DIM_W | Active width in pixels |
| v_act_i | input | DIM_W | Active height in lines |
| busy_o | output | 1 | Packet build or send in progress |
| pkt_valid_o | output | 1 | Output byte valid |
| pkt_ready_i | input | 1 | Sink accepts byte |
| pkt_data_o | output | 8 | Packet byte |
| pkt_idx_o | output | 5 | Byte index 0..16 |
| pkt_last_o | output | 1 | Final byte of packet |

## Verification
The hardest case to reach from the ports is a packet stalled partway through while the sink withholds ready. During that stall, the frozen byte must not move. At the same time, a second start pulse and new mode inputs arrive, and the checksum already formed must stay correct. To get there, the stimulus changes all mode inputs and pulses start during the checksum pass. It then drops ready on alternate cycles through the whole send, and compares every held byte and the final packet sum. The colorimetry and aspect boundaries get their own runs: 27000 versus 27001 kHz, a ratio of exactly 156 versus 155, and a height of zero.

// File: rtl/avi_pkt_pkg.sv
package avi_pkt_pkg;
  localparam int unsigned PKT_LEN  = 17;
  localparam int unsigned IDX_W    = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);
  localparam logic [IDX_W-1:0] CSUM_IDX = IDX_W'(3);
  localparam logic [IDX_W-1:0] PIC_IDX  = IDX_W'(5);

  localparam logic [7:0] COL_SD  = 8'h40;
  localparam logic [7:0] COL_HD  = 8'h80;
  localparam logic [7:0] ASP_NAR = 8'h18;
  localparam logic [7:0] ASP_WID = 8'h28;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SUM  = 2'd1,
    PH_SEND = 2'd2
  } phase_t;

  function automatic logic [7:0] fixed_byte(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0): fixed_byte = 8'h82;
      IDX_W'(1): fixed_byte = 8'h02;
      IDX_W'(2): fixed_byte = 8'h0D;
      IDX_W'(4): fixed_byte = 8'h12;
      IDX_W'(6): fixed_byte = 8'h88;
      default:   fixed_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/avi_mode_classify.sv
module avi_mode_classify #(
  parameter int CLK_W        = 20,
  parameter int DIM_W        = 12,
  parameter int SD_LIMIT_KHZ = 27000,
  parameter int RATIO_SCALE  = 100,
  parameter int RATIO_LIMIT  = 156
) (
  input  logic [CLK_W-1:0] pclk_khz,
  input  logic [DIM_W-1:0] h_act,
  input  logic [DIM_W-1:0] v_act,
  output logic [7:0]       pic_code
);
  import avi_pkt_pkg::*;
  localparam int PROD_W = DIM_W + 9;

  logic [PROD_W-1:0] scaled_w;
  logic [PROD_W-1:0] limit_h;
  logic              narrow;
  logic [7:0]        col_bits;

  // floor(w*S/h) < L  <=>  w*S < L*h  for h > 0
  assign scaled_w = PROD_W'(h_act) * PROD_W'(RATIO_SCALE);
  assign limit_h  = PROD_W'(v_act) * PROD_W'(RATIO_LIMIT);
  assign narrow   = (v_act != '0) && (scaled_w < limit_h);
  assign col_bits = (pclk_khz <= CLK_W'(SD_LIMIT_KHZ)) ? COL_SD : COL_HD;
  assign pic_code = col_bits | (narrow ? ASP_NAR : ASP_WID);
endmodule

// File: rtl/avi_byte_source.sv
module avi_byte_source
  import avi_pkt_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       pic_code,
  input  logic [7:0]       csum,
  input  logic             patch_csum,
  output logic [7:0]       byte_o
);
  always_comb begin
    byte_o = fixed_byte(idx);
    if (idx == PIC_IDX)  byte_o = pic_code;
    if (idx == CSUM_IDX) byte_o = patch_csum ? csum : 8'h00;
  end
endmodule

// File: rtl/avi_csum_acc.sv
module avi_csum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       add_en,
  input  logic [7:0] add_byte,
  output logic [7:0] csum
);
  logic [7:0] total_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      total_q <= 8'h00;
    else if (clear)  total_q <= 8'h00;
    else if (add_en) total_q <= total_q + add_byte;
  end

  assign csum = 8'h00 - total_q;
endmodule

// File: rtl/avi_pkt_builder.sv
module avi_pkt_builder
  import avi_pkt_pkg::*;
#(
  parameter int CLK_W        = 20,
  parameter int DIM_W        = 12,
  parameter int SD_LIMIT_KHZ = 27000,
  parameter int RATIO_LIMIT  = 156
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CLK_W-1:0] pclk_khz_i,
  input  logic [DIM_W-1:0] h_act_i,
  input  logic [DIM_W-1:0] v_act_i,
  output logic             busy_o,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic [7:0]       pkt_data_o,
  output logic [4:0]       pkt_idx_o,
  output logic             pkt_last_o
);
  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       pic_q;
  logic [7:0]       pic_now;
  logic [7:0]       csum;
  logic [7:0]       cur_byte;
  logic             accept;
  logic             at_last;

  avi_mode_classify #(
    .CLK_W(CLK_W), .DIM_W(DIM_W), .SD_LIMIT_KHZ(SD_LIMIT_KHZ),
    .RATIO_SCALE(100), .RATIO_LIMIT(RATIO_LIMIT)
  ) u_classify (
    .pclk_khz(pclk_khz_i), .h_act(h_act_i), .v_act(v_act_i),
    .pic_code(pic_now)
  );

  avi_byte_source u_src (
    .idx(idx_q), .pic_code(pic_q), .csum(csum),
    .patch_csum(phase_q == PH_SEND), .byte_o(cur_byte)
  );

  avi_csum_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .add_en(phase_q == PH_SUM), .add_byte(cur_byte), .csum(csum)
  );

  assign accept  = (phase_q == PH_IDLE) && start_i;
  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      pic_q   <= 8'h00;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SUM;
          idx_q   <= '0;
          pic_q   <= pic_now;
        end
        PH_SUM: begin
          if (at_last) begin
            phase_q <= PH_SEND;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_SEND: if (pkt_ready_i) begin
          if (at_last) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign pkt_valid_o = (phase_q == PH_SEND);
  assign pkt_data_o  = cur_byte;
  assign pkt_idx_o   = 5'(idx_q);
  assign pkt_last_o  = (phase_q == PH_SEND) && at_last;
endmodule

// File: rtl/avi_pkt_builder_chk.sv
module avi_pkt_builder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       pkt_valid_o,
  input logic       pkt_ready_i,
  input logic [7:0] pkt_data_o,
  input logic [4:0] pkt_idx_o,
  input logic       pkt_last_o
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_idx_o) && $stable(pkt_last_o));

  p_last_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && pkt_last_o |-> pkt_idx_o == 5'd16);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && pkt_ready_i && !pkt_last_o |=> pkt_valid_o && pkt_idx_o == $past(pkt_idx_o) + 5'd1);

  p_first_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid_o) |-> pkt_idx_o == 5'd0);

  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && pkt_ready_i && pkt_last_o |=> !pkt_valid_o && !busy_o);

  p_pic_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && pkt_idx_o == 5'd5 |->
      (pkt_data_o == 8'h58 || pkt_data_o == 8'h68 || pkt_data_o == 8'h98 || pkt_data_o == 8'hA8));

  p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> busy_o);
endmodule

bind avi_pkt_builder avi_pkt_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .pkt_valid_o(pkt_valid_o),
  .pkt_ready_i(pkt_ready_i), .pkt_data_o(pkt_data_o), .pkt_idx_o(pkt_idx_o),
  .pkt_last_o(pkt_last_o)
);

// File: tb/avi_pkt_builder_tb.sv
module avi_pkt_builder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] pclk_khz_i = '0;
  logic [11:0] h_act_i = '0;
  logic [11:0] v_act_i = '0;
  logic        pkt_ready_i = 1'b0;
  logic        busy_o, pkt_valid_o, pkt_last_o;
  logic [7:0]  pkt_data_o;
  logic [4:0]  pkt_idx_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] rx [17];
  logic [7:0] ex [17];

  always #(CLK_PERIOD/2) clk = ~clk;

  avi_pkt_builder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pclk_khz_i(pclk_khz_i),
    .h_act_i(h_act_i), .v_act_i(v_act_i), .busy_o(busy_o),
    .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i),
    .pkt_data_o(pkt_data_o), .pkt_idx_o(pkt_idx_o), .pkt_last_o(pkt_last_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic build_expect(input int pk, input int h, input int v);
    int sum = 0;
    int b5 = (pk <= 27000) ? 'h40 : 'h80;
    b5 |= (v != 0 && (h * 100) / v < 156) ? 'h18 : 'h28;
    for (int i = 0; i < 17; i++) ex[i] = 8'h00;
    ex[0] = 8'h82; ex[1] = 8'h02; ex[2] = 8'h0D; ex[4] = 8'h12;
    ex[5] = 8'(b5); ex[6] = 8'h88;
    for (int i = 0; i < 17; i++) sum += ex[i];
    ex[3] = 8'(256 - (sum % 256));
  endtask

  // Launch a packet, optionally disturbing inputs while busy; stall on odd cycles if asked.
  task automatic run_packet(input string name, input int pk, input int h, input int v,
                            input bit disturb, input bit stall);
    int cnt = 0;
    int n = 0;
    int sum = 0;
    bit held = 0;
    logic [7:0] hd;
    logic [4:0] hi;
    build_expect(pk, h, v);
    @(negedge clk);
    pclk_khz_i = 20'(pk); h_act_i = 12'(h); v_act_i = 12'(v);
    pkt_ready_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!pkt_valid_o && cnt < 40) begin
      if (disturb && cnt == 5) begin
        start_i = 1'b1; pclk_khz_i = 20'd99999; h_act_i = 12'd1; v_act_i = 12'd7;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    check(cnt == 17, {name, " R3 latency"}, cnt, 17);
    for (int cyc = 0; cyc < 60 && n < 17; cyc++) begin
      if (held) begin
        check(pkt_valid_o && pkt_data_o == hd && pkt_idx_o == hi,
              {name, " R9 hold"}, pkt_data_o, hd);
      end
      pkt_ready_i = stall ? cyc[0] : 1'b1;
      held = pkt_valid_o && !pkt_ready_i;
      hd = pkt_data_o; hi = pkt_idx_o;
      if (pkt_valid_o && pkt_ready_i) begin
        if (pkt_idx_o != 5'(n) || pkt_last_o != (n == 16))
          check(0, {name, " R4 order"}, pkt_idx_o, n);
        rx[n] = pkt_data_o;
        n++;
      end
      @(negedge clk);
    end
    pkt_ready_i = 1'b0;
    check(n == 17, {name, " R4 count"}, n, 17);
    check(!pkt_valid_o && !busy_o, {name, " R10 end"}, pkt_valid_o, 0);
    for (int i = 0; i < 17; i++) begin
      sum += rx[i];
      if (rx[i] != ex[i]) check(0, {name, " R4 byte"}, rx[i], ex[i]);
    end
    check(rx[5] == ex[5], {name, " R5 R6 descriptor"}, rx[5], ex[5]);
    check(rx[3] == ex[3], {name, " R8 checksum byte"}, rx[3], ex[3]);
    check(sum % 256 == 0, {name, " R8 sum"}, sum % 256, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!pkt_valid_o, "R1 valid", pkt_valid_o, 0);
    check(!busy_o, "R1 busy", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_packet("sd_4x3",   25175,  640,  480, 0, 0);   // R5 R6: 0x58
    run_packet("hd_16x9", 148500, 1920, 1080, 0, 0);   // 0xA8
    run_packet("hd_4x3",   65000, 1024,  768, 0, 0);   // 0x98
    run_packet("sd_edge",  27000,  720,  400, 0, 0);   // R5 boundary: 0x68
    run_packet("hd_edge",  27001, 1560, 1000, 0, 0);   // R6 ratio 156: 0xA8
    run_packet("ratio155", 27001, 1559, 1000, 0, 0);   // R6 ratio 155: 0x98
    run_packet("zero_h",   30000,  800,    0, 0, 0);   // R7: 0xA8
    run_packet("busy_ign", 25200,  640,  480, 1, 0);   // R2
    run_packet("stall",    74250, 1280,  720, 1, 1);   // R9 R2
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule